// File: doc/BRIEF.md
# Palette Color Remapper

This block is the final color stage of a bitmap display controller that shows 320x200 pixels in 16 colors. Each pixel arrives as a 4-bit code built from four plane bits. Plane I is bit 0, plane II is bit 1, plane III is bit 2 and plane IV is bit 3. Planes III and IV name one of four color groups. A programmable group select picks one of these groups. A pixel in the picked group does not show its own color: planes I and II pick one of four palette entries, and that entry supplies the color. A pixel in any other group shows its own code unchanged.

Outside the active display area the block shows a programmable border color. Software loads the border, the palette entries and the group select over a byte-wide write port. The port decodes a high and a low address byte, in the manner of an indirect output instruction. The output is one registered 4-bit color. Its encoding is bit 0 = blue, bit 1 = red, bit 2 = green and bit 3 = intensity, so code 0 is black, 7 is white, 8 is gray and 15 is bright white.

Top module: `pal_color_stage`

## Requirements
- R1: After reset, the border, all four palette entries and the group select are 0. With `active` low, `irgb` reads 0.
- R2: With `active` high and `pix_code[3:2]` equal to the group select, `irgb` equals the palette entry indexed by `pix_code[1:0]`.
- R3: With `active` high and `pix_code[3:2]` different from the group select, `irgb` equals `pix_code`.
- R4: With `active` low, `irgb` equals the border register, whatever `pix_code` holds.
- R5: A write with `wr_addr_hi`=0x06 and `wr_addr_lo`=0xCF loads `wr_data[3:0]` into the border register.
- R6: A write with `wr_addr_hi`=0x07, `wr_addr_lo`=0xCF and `wr_data[7:6]`=00 loads `wr_data[3:0]` into the palette entry numbered by `wr_data[5:4]`.
- R7: A write to the same address with `wr_data[7:6]`=01 loads the group select from `wr_data[1:0]`. Bit 0 is matched against plane III and bit 1 against plane IV, so the value 2 selects the group with plane IV=1 and plane III=0.
- R8: A cycle with `wr_en` low, any other address pair, or `wr_data[7]`=1 on the palette address leaves the border, the palette and the group select unchanged.
- R9: `irgb` is registered, with one cycle of latency from `pix_code` and `active`. A register write takes effect from the output sampled on the clock edge after the write edge, even during active display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr_hi | input | 8 | High address byte of the write |
| wr_addr_lo | input | 8 | Low port address byte of the write |
| wr_data | input | 8 | Write data byte |
| pix_code | input | 4 | Pixel code, one bit from each plane, plane I in bit 0 |
| active | input | 1 | High inside the active display area |
| irgb | output | 4 | Registered output color, bit 0 blue, bit 1 red, bit 2 green, bit 3 intensity |

## Verification
The bench builds the block with its defaults: a 4-bit color, four palette entries and a 2-bit group select. At this size every state can be swept in full. The bench walks all four group selects. For each one it loads a distinct palette and drives all 16 pixel codes, which covers both the remapped group and the three pass-through groups. It also cycles the border through all 16 colors, tries each near-miss address and the reserved data bit, and writes during the pixel cycle to show when a new value first appears on the output.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int COLOR_W = 4;
  localparam int N_ENT   = 4;
  localparam int IDX_W   = $clog2(N_ENT);
  localparam int GRP_W   = COLOR_W - IDX_W;

  typedef logic [COLOR_W-1:0] color_t;
  typedef logic [GRP_W-1:0]   grp_t;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_BORDER,
    WR_ENTRY,
    WR_GROUP
  } wr_kind_e;
endpackage

// File: rtl/pal_reset_sync.sv
module pal_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pal_regs.sv
module pal_regs
  import pal_pkg::*;
#(
  parameter logic [7:0] BORDER_HI = 8'h06,
  parameter logic [7:0] PAL_HI    = 8'h07,
  parameter logic [7:0] PORT_LO   = 8'hCF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           wr_addr_hi,
  input  logic [7:0]           wr_addr_lo,
  input  logic [7:0]           wr_data,
  output color_t               border_q,
  output color_t [N_ENT-1:0]   pal_q,
  output grp_t                 grp_q
);
  localparam int SEL_BIT = COLOR_W + IDX_W;

  wr_kind_e           kind;
  logic [IDX_W-1:0]   ent_sel;
  color_t             wr_color;
  color_t             border_d;
  grp_t               grp_d;
  logic               border_en;
  logic               grp_en;
  logic [N_ENT-1:0]   ent_en;

  assign ent_sel  = wr_data[COLOR_W +: IDX_W];
  assign wr_color = wr_data[COLOR_W-1:0];

  always_comb begin
    kind = WR_NONE;
    if (wr_en && wr_addr_lo == PORT_LO) begin
      if (wr_addr_hi == BORDER_HI) begin
        kind = WR_BORDER;
      end else if (wr_addr_hi == PAL_HI && !wr_data[7]) begin
        kind = wr_data[SEL_BIT] ? WR_GROUP : WR_ENTRY;
      end
    end
  end

  always_comb begin
    border_en = (kind == WR_BORDER);
    grp_en    = (kind == WR_GROUP);
    border_d  = wr_color;
    grp_d     = wr_data[GRP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         border_q <= '0;
    else if (border_en) border_q <= border_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grp_q <= '0;
    else if (grp_en) grp_q <= grp_d;
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_entry
    always_comb ent_en[e] = (kind == WR_ENTRY) && (ent_sel == e[IDX_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pal_q[e] <= '0;
      else if (ent_en[e]) pal_q[e] <= wr_color;
    end
  end
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_pkg::*;
(
  input  color_t               pix_code,
  input  logic                 active,
  input  color_t               border,
  input  color_t [N_ENT-1:0]   pal,
  input  grp_t                 grp,
  output color_t               color_d
);
  logic in_group;

  always_comb begin
    in_group = (pix_code[COLOR_W-1:IDX_W] == grp);
    if (!active)       color_d = border;
    else if (in_group) color_d = pal[pix_code[IDX_W-1:0]];
    else               color_d = pix_code;
  end
endmodule

// File: rtl/pal_color_stage.sv
module pal_color_stage
  import pal_pkg::*;
#(
  parameter logic [7:0] BORDER_HI = 8'h06,
  parameter logic [7:0] PAL_HI    = 8'h07,
  parameter logic [7:0] PORT_LO   = 8'hCF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr_hi,
  input  logic [7:0]         wr_addr_lo,
  input  logic [7:0]         wr_data,
  input  logic [COLOR_W-1:0] pix_code,
  input  logic               active,
  output logic [COLOR_W-1:0] irgb
);
  logic               rst_sync_n;
  color_t             border_q;
  color_t [N_ENT-1:0] pal_q;
  grp_t               grp_q;
  color_t             color_d;
  color_t             irgb_q;

  pal_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pal_regs #(
    .BORDER_HI (BORDER_HI),
    .PAL_HI    (PAL_HI),
    .PORT_LO   (PORT_LO)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_addr_hi (wr_addr_hi),
    .wr_addr_lo (wr_addr_lo),
    .wr_data    (wr_data),
    .border_q   (border_q),
    .pal_q      (pal_q),
    .grp_q      (grp_q)
  );

  pal_lookup u_lookup (
    .pix_code (pix_code),
    .active   (active),
    .border   (border_q),
    .pal      (pal_q),
    .grp      (grp_q),
    .color_d  (color_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irgb_q <= '0;
    else             irgb_q <= color_d;
  end

  assign irgb = irgb_q;
endmodule

// File: rtl/pal_color_stage_chk.sv
module pal_color_stage_chk
  import pal_pkg::*;
(
  input logic               clk,
  input logic               rst_sync_n,
  input logic               wr_en,
  input logic [7:0]         wr_addr_hi,
  input logic [7:0]         wr_addr_lo,
  input logic [7:0]         wr_data,
  input logic [COLOR_W-1:0] pix_code,
  input logic               active,
  input logic [COLOR_W-1:0] irgb,
  input color_t             border_q,
  input color_t [N_ENT-1:0] pal_q,
  input grp_t               grp_q
);
  logic hit_border;
  logic hit_pal;
  assign hit_border = wr_en && wr_addr_hi == 8'h06 && wr_addr_lo == 8'hCF;
  assign hit_pal    = wr_en && wr_addr_hi == 8'h07 && wr_addr_lo == 8'hCF && !wr_data[7];

  assert_border_out_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !active |=> irgb == $past(border_q));

  assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active && pix_code[COLOR_W-1:IDX_W] != grp_q) |=> irgb == $past(pix_code));

  assert_remap_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active && pix_code[COLOR_W-1:IDX_W] == grp_q) |=> irgb == $past(pal_q[pix_code[IDX_W-1:0]]));

  assert_border_load_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_border |=> border_q == $past(wr_data[COLOR_W-1:0]));

  assert_border_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit_border |=> $stable(border_q));

  assert_group_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(hit_pal && wr_data[6]) |=> $stable(grp_q));

  assert_pal_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(hit_pal && !wr_data[6]) |=> $stable(pal_q));
endmodule

bind pal_color_stage pal_color_stage_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr_hi (wr_addr_hi),
  .wr_addr_lo (wr_addr_lo),
  .wr_data    (wr_data),
  .pix_code   (pix_code),
  .active     (active),
  .irgb       (irgb),
  .border_q   (border_q),
  .pal_q      (pal_q),
  .grp_q      (grp_q)
);

// File: tb/test_pal_color_stage.sv
`timescale 1ns/1ps
module test_pal_color_stage;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr_hi;
  logic [7:0] wr_addr_lo;
  logic [7:0] wr_data;
  logic [3:0] pix_code;
  logic       active;
  logic [3:0] irgb;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [3:0] m_pal [4];
  logic [1:0] m_grp;
  logic [3:0] m_border;

  pal_color_stage i_pal_color_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr_hi (wr_addr_hi),
    .wr_addr_lo (wr_addr_lo),
    .wr_data    (wr_data),
    .pix_code   (pix_code),
    .active     (active),
    .irgb       (irgb)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: irgb=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] hi, logic [7:0] lo, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr_hi = hi; wr_addr_lo = lo; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_grp(logic [1:0] g);
    wr(8'h07, 8'hCF, {2'b01, 4'h0, g});
    m_grp = g;
  endtask

  task automatic set_ent(int e, logic [3:0] c);
    wr(8'h07, 8'hCF, {2'b00, e[1:0], c});
    m_pal[e] = c;
  endtask

  task automatic set_border(logic [3:0] c);
    wr(8'h06, 8'hCF, {4'h0, c});
    m_border = c;
  endtask

  function automatic logic [3:0] expect_px(logic [3:0] code, logic act);
    if (!act) return m_border;
    if (code[3:2] == m_grp) return m_pal[code[1:0]];
    return code;
  endfunction

  task automatic pix(string req, logic [3:0] code, logic act);
    @(negedge clk);
    pix_code = code; active = act;
    @(posedge clk);
    #5;
    check(req, irgb, expect_px(code, act));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: irgb=%0d expected=done", irgb);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr_hi = 0; wr_addr_lo = 0; wr_data = 0;
    pix_code = 4'h9; active = 0;
    for (int e = 0; e < 4; e++) m_pal[e] = 0;
    m_grp = 0; m_border = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state seen through border and palette paths
    pix("R1 border after reset", 4'h9, 0);
    pix("R1 palette after reset", 4'h3, 1);
    pix("R1 group after reset", 4'h7, 1);

    // R2 R3 R6 R7: every group select, every code
    for (int g = 0; g < 4; g++) begin
      set_grp(g[1:0]);
      for (int e = 0; e < 4; e++) set_ent(e, 4'((g * 5 + e * 3 + 1) & 15));
      for (int c = 0; c < 16; c++)
        pix((c[3:2] == g[1:0]) ? "R2 R6 R7 remap" : "R3 pass-through", c[3:0], 1);
    end

    // R4 R5: every border color, varied pixel code
    for (int b = 0; b < 16; b++) begin
      set_border(b[3:0]);
      pix("R4 R5 border", 4'(15 - b), 0);
    end

    // R8: writes that must not land
    set_border(4'h3);
    set_grp(2'd1);
    for (int e = 0; e < 4; e++) set_ent(e, 4'(8 + e));
    wr(8'h06, 8'hCE, 8'h0C);
    wr(8'h05, 8'hCF, 8'h0C);
    wr(8'h07, 8'hCF, 8'h8C);
    wr(8'h07, 8'hCF, 8'hC2);
    @(negedge clk);
    wr_en = 0; wr_addr_hi = 8'h06; wr_addr_lo = 8'hCF; wr_data = 8'h0C;
    @(negedge clk);
    pix("R8 border unchanged", 4'h0, 0);
    for (int c = 0; c < 16; c++) pix("R8 palette and group unchanged", c[3:0], 1);

    // R9: border written in the pixel cycle
    @(negedge clk);
    pix_code = 4'h0; active = 0;
    wr_en = 1; wr_addr_hi = 8'h06; wr_addr_lo = 8'hCF; wr_data = 8'h0A;
    @(posedge clk); #5;
    check("R9 border old value on write edge", irgb, 4'h3);
    @(negedge clk);
    wr_en = 0;
    @(posedge clk); #5;
    check("R9 border new value next edge", irgb, 4'hA);
    m_border = 4'hA;

    // R9: palette entry written during active display
    @(negedge clk);
    pix_code = 4'h5; active = 1;
    wr_en = 1; wr_addr_hi = 8'h07; wr_addr_lo = 8'hCF; wr_data = 8'h1E;
    @(posedge clk); #5;
    check("R9 palette old value on write edge", irgb, 4'h9);
    @(negedge clk);
    wr_en = 0;
    @(posedge clk); #5;
    check("R9 palette new value next edge", irgb, 4'hE);
    m_pal[1] = 4'hE;

    // R9: output follows active with one cycle latency
    pix("R9 latency active", 4'hC, 1);
    pix("R9 latency inactive", 4'hC, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule